// File: doc/BRIEF.md
# Cipher engine command queue decoder

The block sits between a host write port and a block-cipher engine. The host pushes 32-bit command words into a small inbound queue. A decoder pops the words and reads the opcode in the top field of each one. Some commands also take one operand word. From these the decoder drives four requests toward the rest of the engine:

- a data-setup address;
- a block-start pulse with a block count;
- a copy between external memory and internal RAM, with direction and word count;
- a key-table load, with table, RAM and slot selects.

The cipher core, the memory bus and the internal RAM are outside the block. They answer through done and acknowledge inputs.

The host polls three flags before each push: engine-busy, queue-empty and DMA-busy. Completions and errors set bits in a sticky interrupt status vector. The host clears these bits by writing ones. An enable mask gates the bits onto a single interrupt line.

Top module: `cmdq_decoder`

## Requirements
- R1: After reset the queue is empty, `q_empty_o`=1, `eng_busy_o`=0, `dma_busy_o`=0, `int_status_o`=0, `irq_o`=0, and the `blk_start_o`, `setup_valid_o`, `copy_req_o` and `tbl_req_o` outputs are all 0.
- R2: The queue stores up to 5 words and returns them in push order. `q_empty_o` is 1 exactly when no word is stored.
- R3: A push while 5 words are stored is dropped and sets status bit 5 (overflow). The stored words are left unchanged.
- R4: The opcode is bits [31:26]. Opcode 0x10 (data setup) takes the next word as its address. When that word is popped, `setup_valid_o` pulses for one cycle and `setup_addr_o` holds the address.
- R5: Opcode 0x0E (block start) pulses `blk_start_o` in the cycle after the pop. `blk_count_o` is bits [11:0] plus one, so a field of 0 means one block. The decoder then waits for `blk_done_i`, which sets status bit 2.
- R6: Opcode 0x22 (copy) takes its direction from bit 25 (0 means external memory to internal RAM, 1 means the reverse) and its word count from bits [24:12]. The next word is the external address. `copy_req_o` and `dma_busy_o` stay high, with stable fields, until `copy_ack_i` is high. That acknowledge sets status bit 1.
- R7: Opcode 0x15 (table load) drives these fields, then holds `tbl_req_o` until `tbl_ack_i`, which sets status bit 3:
  - `tbl_sel_o` from bits [25:24];
  - `ram_sel_o` from bit 23;
  - `key_slot_o` from bits [19:17], where the key-table ID in bits [20:17] is a marker of 8 ORed with the slot;
  - `key_addr_o` from bits [16:0].
- R8: Opcode 0x11 (transfer complete) sets status bit 0 and does not stall the queue. Any other opcode sets status bit 4, is discarded, and the next word is decoded in the following cycle.
- R9: `int_status_o` bits are sticky. A one in `int_clr_i` clears the matching bit in the next cycle, but an event in the same cycle wins. `irq_o` is 1 when any status bit with its `int_en_i` bit set is 1; the enable value 0x33 selects bits 0, 1, 4 and 5.
- R10: `eng_busy_o` is 1 while the decoder waits for an operand word or a done or acknowledge input. `dma_busy_o` is never 1 while `eng_busy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_valid_i | input | 1 | Host pushes a command word |
| push_data_i | input | 32 | Pushed command word |
| int_clr_i | input | 8 | Write-one-to-clear mask for status |
| int_en_i | input | 8 | Interrupt enable mask |
| setup_valid_o | output | 1 | One-cycle pulse: setup address delivered |
| setup_addr_o | output | 32 | Input buffer address |
| blk_start_o | output | 1 | One-cycle block-start pulse |
| blk_count_o | output | 13 | Number of blocks to process |
| blk_done_i | input | 1 | Cipher core finished the blocks |
| copy_req_o | output | 1 | Copy request, held until acknowledge |
| copy_dir_o | output | 1 | 0: external to internal RAM, 1: reverse |
| copy_words_o | output | 13 | Copy length in 32-bit words |
| copy_addr_o | output | 32 | External address of the copy |
| copy_ack_i | input | 1 | Copy finished |
| tbl_req_o | output | 1 | Key-table load request, held until acknowledge |
| tbl_sel_o | output | 2 | Table select |
| ram_sel_o | output | 1 | RAM select |
| key_slot_o | output | 3 | Key slot number |
| key_addr_o | output | 17 | Key address in internal RAM |
| tbl_ack_i | input | 1 | Key-table load finished |
| eng_busy_o | output | 1 | Decoder is mid-command |
| q_empty_o | output | 1 | Inbound queue holds no word |
| dma_busy_o | output | 1 | A copy is in flight |
| int_status_o | output | 8 | Sticky event status |
| irq_o | output | 1 | Interrupt line |

## Verification
The following properties are checked on every cycle:
- a push into a full queue always sets the overflow bit;
- `blk_start_o` never lasts more than one cycle;
- the copy and table requests hold, with stable fields, until acknowledged;
- `dma_busy_o` implies `eng_busy_o`;
- a full queue is never reported empty.

Other behaviours show only in the bench's scenarios, which compare against a behavioural reference model:
- field extraction for each opcode;
- the block count being the field plus one;
- word order through the queue after a drop;
- discarding a bad opcode without a stall;
- a set event beating a clear in the same cycle.

// File: rtl/cqd_pkg.sv
package cqd_pkg;
  localparam int WORD_W   = 32;
  localparam int OP_LSB   = 26;
  localparam int OP_W     = WORD_W - OP_LSB;
  localparam int DIR_BIT  = 25;
  localparam int WC_LSB   = 12;
  localparam int WC_W     = DIR_BIT - WC_LSB;
  localparam int CNT_W    = 12;
  localparam int TSEL_LSB = 24;
  localparam int TSEL_W   = OP_LSB - TSEL_LSB;
  localparam int RSEL_BIT = 23;
  localparam int KID_LSB  = 17;
  localparam int SLOT_W   = 3;
  localparam int KA_W     = KID_LSB;
  localparam int ST_W     = 8;

  localparam logic [OP_W-1:0] OP_BLK   = 6'h0E;
  localparam logic [OP_W-1:0] OP_SETUP = 6'h10;
  localparam logic [OP_W-1:0] OP_DONE  = 6'h11;
  localparam logic [OP_W-1:0] OP_TBL   = 6'h15;
  localparam logic [OP_W-1:0] OP_COPY  = 6'h22;

  localparam int EV_XFER  = 0;
  localparam int EV_COPY  = 1;
  localparam int EV_BLK   = 2;
  localparam int EV_TBL   = 3;
  localparam int EV_BADOP = 4;
  localparam int EV_OVF   = 5;
  localparam int PEV_W    = EV_BADOP + 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPND, ST_BLK, ST_COPY, ST_TBL
  } cqd_state_e;
endpackage

// File: rtl/cqd_fifo.sv
module cqd_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          drop_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic wr_ok, rd_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign drop_o  = push_i && full_o;
  assign wr_ok   = push_i && !full_o;
  assign rd_ok   = pop_i && !empty_o;
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ok) wr_q <= (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + AW'(1);
      if (rd_ok) rd_q <= (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + AW'(1);
      case ({wr_ok, rd_ok})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/cqd_parser.sv
module cqd_parser
  import cqd_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [WORD_W-1:0]   word_i,
  input  logic                avail_i,
  output logic                pop_o,
  output logic                setup_valid_o,
  output logic [WORD_W-1:0]   setup_addr_o,
  output logic                blk_start_o,
  output logic [CNT_W:0]      blk_count_o,
  input  logic                blk_done_i,
  output logic                copy_req_o,
  output logic                copy_dir_o,
  output logic [WC_W-1:0]     copy_words_o,
  output logic [WORD_W-1:0]   copy_addr_o,
  input  logic                copy_ack_i,
  output logic                tbl_req_o,
  output logic [TSEL_W-1:0]   tbl_sel_o,
  output logic                ram_sel_o,
  output logic [SLOT_W-1:0]   key_slot_o,
  output logic [KA_W-1:0]     key_addr_o,
  input  logic                tbl_ack_i,
  output logic                busy_o,
  output logic [PEV_W-1:0]    ev_o
);
  cqd_state_e st_q;
  logic opnd_copy_q;
  logic [OP_W-1:0] op;
  logic known;

  assign op     = word_i[WORD_W-1:OP_LSB];
  assign pop_o  = avail_i && (st_q == ST_IDLE || st_q == ST_OPND);
  assign busy_o = (st_q != ST_IDLE);
  assign known  = (op == OP_BLK) || (op == OP_SETUP) || (op == OP_DONE) ||
                  (op == OP_TBL) || (op == OP_COPY);

  always_comb begin
    ev_o = '0;
    ev_o[EV_XFER]  = pop_o && (st_q == ST_IDLE) && (op == OP_DONE);
    ev_o[EV_BADOP] = pop_o && (st_q == ST_IDLE) && !known;
    ev_o[EV_BLK]   = (st_q == ST_BLK) && blk_done_i;
    ev_o[EV_COPY]  = (st_q == ST_COPY) && copy_ack_i;
    ev_o[EV_TBL]   = (st_q == ST_TBL) && tbl_ack_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= ST_IDLE;
      opnd_copy_q   <= 1'b0;
      setup_valid_o <= 1'b0;
      setup_addr_o  <= '0;
      blk_start_o   <= 1'b0;
      blk_count_o   <= '0;
      copy_req_o    <= 1'b0;
      copy_dir_o    <= 1'b0;
      copy_words_o  <= '0;
      copy_addr_o   <= '0;
      tbl_req_o     <= 1'b0;
      tbl_sel_o     <= '0;
      ram_sel_o     <= 1'b0;
      key_slot_o    <= '0;
      key_addr_o    <= '0;
    end else begin
      setup_valid_o <= 1'b0;
      blk_start_o   <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (pop_o) begin
          if (op == OP_SETUP) begin
            opnd_copy_q <= 1'b0;
            st_q        <= ST_OPND;
          end else if (op == OP_COPY) begin
            opnd_copy_q  <= 1'b1;
            copy_dir_o   <= word_i[DIR_BIT];
            copy_words_o <= word_i[DIR_BIT-1:WC_LSB];
            st_q         <= ST_OPND;
          end else if (op == OP_BLK) begin
            blk_start_o <= 1'b1;
            blk_count_o <= {1'b0, word_i[CNT_W-1:0]} + (CNT_W+1)'(1);
            st_q        <= ST_BLK;
          end else if (op == OP_TBL) begin
            tbl_req_o  <= 1'b1;
            tbl_sel_o  <= word_i[OP_LSB-1:TSEL_LSB];
            ram_sel_o  <= word_i[RSEL_BIT];
            key_slot_o <= word_i[KID_LSB+SLOT_W-1:KID_LSB];
            key_addr_o <= word_i[KA_W-1:0];
            st_q       <= ST_TBL;
          end
        end
        ST_OPND: if (pop_o) begin
          if (opnd_copy_q) begin
            copy_addr_o <= word_i;
            copy_req_o  <= 1'b1;
            st_q        <= ST_COPY;
          end else begin
            setup_addr_o  <= word_i;
            setup_valid_o <= 1'b1;
            st_q          <= ST_IDLE;
          end
        end
        ST_BLK:  if (blk_done_i) st_q <= ST_IDLE;
        ST_COPY: if (copy_ack_i) begin
          copy_req_o <= 1'b0;
          st_q       <= ST_IDLE;
        end
        ST_TBL:  if (tbl_ack_i) begin
          tbl_req_o <= 1'b0;
          st_q      <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cqd_irq.sv
module cqd_irq #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ev_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] status_o,
  output logic         irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_o <= '0;
    else         status_o <= (status_o & ~clr_i) | ev_i;  // set wins
  end
  assign irq_o = |(status_o & en_i);
endmodule

// File: rtl/cmdq_decoder.sv
module cmdq_decoder
  import cqd_pkg::*;
#(
  parameter int DEPTH = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                push_valid_i,
  input  logic [WORD_W-1:0]   push_data_i,
  input  logic [ST_W-1:0]     int_clr_i,
  input  logic [ST_W-1:0]     int_en_i,
  output logic                setup_valid_o,
  output logic [WORD_W-1:0]   setup_addr_o,
  output logic                blk_start_o,
  output logic [CNT_W:0]      blk_count_o,
  input  logic                blk_done_i,
  output logic                copy_req_o,
  output logic                copy_dir_o,
  output logic [WC_W-1:0]     copy_words_o,
  output logic [WORD_W-1:0]   copy_addr_o,
  input  logic                copy_ack_i,
  output logic                tbl_req_o,
  output logic [TSEL_W-1:0]   tbl_sel_o,
  output logic                ram_sel_o,
  output logic [SLOT_W-1:0]   key_slot_o,
  output logic [KA_W-1:0]     key_addr_o,
  input  logic                tbl_ack_i,
  output logic                eng_busy_o,
  output logic                q_empty_o,
  output logic                dma_busy_o,
  output logic [ST_W-1:0]     int_status_o,
  output logic                irq_o
);
  logic [WORD_W-1:0] head_w;
  logic              pop_w, full_w, drop_w;
  logic [PEV_W-1:0]  pev_w;
  logic [ST_W-1:0]   ev_w;

  cqd_fifo #(.DW(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(push_valid_i), .data_i(push_data_i), .pop_i(pop_w),
    .head_o(head_w), .empty_o(q_empty_o), .full_o(full_w), .drop_o(drop_w)
  );

  cqd_parser u_parser (
    .clk_i, .rst_ni,
    .word_i(head_w), .avail_i(!q_empty_o), .pop_o(pop_w),
    .setup_valid_o, .setup_addr_o, .blk_start_o, .blk_count_o, .blk_done_i,
    .copy_req_o, .copy_dir_o, .copy_words_o, .copy_addr_o, .copy_ack_i,
    .tbl_req_o, .tbl_sel_o, .ram_sel_o, .key_slot_o, .key_addr_o, .tbl_ack_i,
    .busy_o(eng_busy_o), .ev_o(pev_w)
  );

  always_comb begin
    ev_w = '0;
    ev_w[PEV_W-1:0] = pev_w;
    ev_w[EV_OVF]    = drop_w;
  end

  assign dma_busy_o = copy_req_o;

  cqd_irq #(.W(ST_W)) u_irq (
    .clk_i, .rst_ni,
    .ev_i(ev_w), .clr_i(int_clr_i), .en_i(int_en_i),
    .status_o(int_status_o), .irq_o
  );
endmodule

// File: rtl/cqd_checker.sv
module cqd_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        push_valid_i,
  input logic        full_w,
  input logic [7:0]  int_status_o,
  input logic        blk_start_o,
  input logic        copy_req_o,
  input logic        copy_ack_i,
  input logic [31:0] copy_addr_o,
  input logic        tbl_req_o,
  input logic        tbl_ack_i,
  input logic [1:0]  tbl_sel_o,
  input logic        dma_busy_o,
  input logic        eng_busy_o,
  input logic        q_empty_o
);
  // R3
  ovf_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_valid_i && full_w) |=> int_status_o[5]);
  // R5
  blk_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_start_o |=> !blk_start_o);
  // R6
  copy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (copy_req_o && !copy_ack_i) |=> (copy_req_o && $stable(copy_addr_o)));
  // R7
  tbl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tbl_req_o && !tbl_ack_i) |=> (tbl_req_o && $stable(tbl_sel_o)));
  // R10
  dma_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_busy_o |-> eng_busy_o);
  // R2
  full_not_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_w |-> !q_empty_o);
endmodule

bind cmdq_decoder cqd_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .push_valid_i(push_valid_i),
  .full_w(full_w), .int_status_o(int_status_o), .blk_start_o(blk_start_o),
  .copy_req_o(copy_req_o), .copy_ack_i(copy_ack_i), .copy_addr_o(copy_addr_o),
  .tbl_req_o(tbl_req_o), .tbl_ack_i(tbl_ack_i), .tbl_sel_o(tbl_sel_o),
  .dma_busy_o(dma_busy_o), .eng_busy_o(eng_busy_o), .q_empty_o(q_empty_o)
);

// File: tb/cmdq_decoder_tb_top.sv
`timescale 1ns/1ps
module cmdq_decoder_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic push_valid = 1'b0;
  logic [31:0] push_data = '0;
  logic [7:0] int_clr = '0, int_en = 8'h33;
  logic blk_done = 1'b0, copy_ack = 1'b0, tbl_ack = 1'b0;
  logic setup_valid, blk_start, copy_req, copy_dir, tbl_req, ram_sel;
  logic eng_busy, q_empty, dma_busy, irq;
  logic [31:0] setup_addr, copy_addr;
  logic [12:0] blk_count, copy_words;
  logic [1:0] tbl_sel;
  logic [2:0] key_slot;
  logic [16:0] key_addr;
  logic [7:0] int_status;

  always #2 clk = ~clk;

  cmdq_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .push_valid_i(push_valid), .push_data_i(push_data),
    .int_clr_i(int_clr), .int_en_i(int_en),
    .setup_valid_o(setup_valid), .setup_addr_o(setup_addr),
    .blk_start_o(blk_start), .blk_count_o(blk_count), .blk_done_i(blk_done),
    .copy_req_o(copy_req), .copy_dir_o(copy_dir), .copy_words_o(copy_words),
    .copy_addr_o(copy_addr), .copy_ack_i(copy_ack),
    .tbl_req_o(tbl_req), .tbl_sel_o(tbl_sel), .ram_sel_o(ram_sel),
    .key_slot_o(key_slot), .key_addr_o(key_addr), .tbl_ack_i(tbl_ack),
    .eng_busy_o(eng_busy), .q_empty_o(q_empty), .dma_busy_o(dma_busy),
    .int_status_o(int_status), .irq_o(irq)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic chk(input string req, input string nm, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, nm, act, exp);
    end
  endtask

  // reference model
  logic [31:0] mq[$];
  int mstate = 0;
  bit mkind = 0;
  logic e_sv, e_bs, e_cr, e_cd, e_tr, e_rs;
  logic [31:0] e_sa, e_ca;
  logic [12:0] e_bc, e_cw;
  logic [1:0] e_ts;
  logic [2:0] e_ks;
  logic [16:0] e_ka;
  logic [7:0] e_int;

  task automatic model_reset();
    mq.delete(); mstate = 0; mkind = 0;
    e_sv = 0; e_bs = 0; e_cr = 0; e_cd = 0; e_tr = 0; e_rs = 0;
    e_sa = 0; e_ca = 0; e_bc = 0; e_cw = 0; e_ts = 0; e_ks = 0; e_ka = 0; e_int = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      logic [7:0] ev;
      logic [31:0] w;
      bit ovf;
      ev = 0; e_sv = 0; e_bs = 0;
      ovf = push_valid && (mq.size() == 5);
      case (mstate)
        0: if (mq.size() > 0) begin
          w = mq.pop_front();
          case (w[31:26])
            6'h10: begin mkind = 0; mstate = 1; end
            6'h22: begin mkind = 1; e_cd = w[25]; e_cw = w[24:12]; mstate = 1; end
            6'h0E: begin e_bs = 1; e_bc = 13'(w[11:0]) + 13'd1; mstate = 2; end
            6'h15: begin e_tr = 1; e_ts = w[25:24]; e_rs = w[23]; e_ks = w[19:17];
                         e_ka = w[16:0]; mstate = 4; end
            6'h11: ev[0] = 1;
            default: ev[4] = 1;
          endcase
        end
        1: if (mq.size() > 0) begin
          w = mq.pop_front();
          if (mkind) begin e_ca = w; e_cr = 1; mstate = 3; end
          else begin e_sa = w; e_sv = 1; mstate = 0; end
        end
        2: if (blk_done) begin mstate = 0; ev[2] = 1; end
        3: if (copy_ack) begin e_cr = 0; mstate = 0; ev[1] = 1; end
        4: if (tbl_ack) begin e_tr = 0; mstate = 0; ev[3] = 1; end
        default: mstate = 0;
      endcase
      if (push_valid && !ovf) mq.push_back(push_data);
      if (ovf) ev[5] = 1;
      e_int = (e_int & ~int_clr) | ev;
    end
  end

  // per-cycle comparison
  always @(negedge clk) if (rst_n && !finished) begin
    chk("R2", "q_empty", q_empty, mq.size() == 0);
    chk("R4", "setup_valid", setup_valid, e_sv);
    chk("R4", "setup_addr", setup_addr, e_sa);
    chk("R5", "blk_start", blk_start, e_bs);
    chk("R5", "blk_count", blk_count, e_bc);
    chk("R6", "copy_req", copy_req, e_cr);
    chk("R6", "copy_fields", {copy_dir, copy_words}, {e_cd, e_cw});
    chk("R6", "copy_addr", copy_addr, e_ca);
    chk("R7", "tbl_req", tbl_req, e_tr);
    chk("R7", "tbl_fields", {tbl_sel, ram_sel, key_slot, key_addr}, {e_ts, e_rs, e_ks, e_ka});
    chk("R8", "int_status", int_status, e_int);
    chk("R9", "irq", irq, |(e_int & int_en));
    chk("R10", "eng_busy", eng_busy, mstate != 0);
    chk("R10", "dma_busy", dma_busy, e_cr);
  end

  // handshake responder
  int blk_lat = 2, blk_wait = 0, c_cnt = 0, t_cnt = 0;
  always @(negedge clk) begin
    blk_done = 0;
    if (blk_wait > 0) begin
      blk_wait--;
      if (blk_wait == 0) blk_done = 1;
    end
    if (blk_start) blk_wait = blk_lat;
    copy_ack = 0;
    if (copy_req) begin c_cnt++; if (c_cnt == 3) begin copy_ack = 1; c_cnt = 0; end end
    tbl_ack = 0;
    if (tbl_req) begin t_cnt++; if (t_cnt == 3) begin tbl_ack = 1; t_cnt = 0; end end
  end

  task automatic push(input logic [31:0] d);
    @(negedge clk); push_valid = 1; push_data = d;
  endtask
  task automatic idle(input int n);
    @(negedge clk); push_valid = 0;
    repeat (n - 1) @(negedge clk);
  endtask
  task automatic clr_all();
    @(negedge clk); push_valid = 0; int_clr = 8'hFF;
    @(negedge clk); int_clr = 0;
  endtask

  localparam logic [31:0] W_DONE  = 32'h11 << 26;
  localparam logic [31:0] W_SETUP = 32'h10 << 26;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "q_empty", q_empty, 1);
    chk("R1", "busy", {eng_busy, dma_busy}, 0);
    chk("R1", "int", {int_status, irq}, 0);
    chk("R1", "reqs", {blk_start, setup_valid, copy_req, tbl_req}, 0);
    rst_n = 1;

    // R8 transfer-complete
    push(W_DONE); idle(4);
    chk("R8", "done bit", int_status, 8'h01);
    chk("R9", "irq on", irq, 1);
    @(negedge clk); int_clr = 8'h01; @(negedge clk); int_clr = 0;
    chk("R9", "cleared", {int_status, irq}, 0);

    // R4 setup
    push(W_SETUP); push(32'h1234_5670); idle(4);
    chk("R4", "setup addr", setup_addr, 32'h1234_5670);

    // R5 block start, field 3 -> 4 blocks; field 0 -> 1 block
    push((32'h0E << 26) | 32'd3); idle(8);
    chk("R5", "count", blk_count, 4);
    chk("R5", "blk done bit", int_status[2], 1);
    push(32'h0E << 26); idle(8);
    chk("R5", "count one", blk_count, 1);

    // R6 copy internal->external, 16 words
    push((32'h22 << 26) | (32'd1 << 25) | (32'd16 << 12)); push(32'hCAFE_0040); idle(10);
    chk("R6", "copy fields", {copy_dir, copy_words}, {1'b1, 13'd16});
    chk("R6", "copy addr", copy_addr, 32'hCAFE_0040);
    chk("R6", "copy bit", int_status[1], 1);

    // R7 table load: table 3, ram 1, id 8|5, addr 0x40
    push((32'h15 << 26) | (32'd3 << 24) | (32'd1 << 23) | (32'd13 << 17) | 32'h40); idle(8);
    chk("R7", "fields", {tbl_sel, ram_sel, key_slot, key_addr}, {2'd3, 1'b1, 3'd5, 17'h40});
    chk("R7", "tbl bit", int_status[3], 1);
    clr_all();

    // R8 bad opcode discarded, next word decoded
    push(32'h3F << 26); push(W_DONE); idle(4);
    chk("R8", "bad+done", int_status, 8'h11);
    clr_all();

    // R3 overflow while engine stalled on a long block
    blk_lat = 30;
    push(32'h0E << 26);
    push(W_SETUP); push(32'hA1); push(W_SETUP); push(32'hA2); push(W_DONE);
    push(32'h3F << 26);
    idle(2);
    chk("R3", "ovf bit", int_status[5], 1);
    chk("R2", "not empty", q_empty, 0);
    idle(40);
    chk("R3", "kept order", setup_addr, 32'hA2);
    chk("R3", "status", int_status, 8'h25);
    chk("R2", "drained", q_empty, 1);
    blk_lat = 2;
    clr_all();

    // R9 set wins over same-cycle clear
    push(W_DONE);
    @(negedge clk); push_valid = 0; int_clr = 8'h01;
    @(negedge clk); int_clr = 0;
    chk("R9", "set wins", int_status[0], 1);
    int_en = 8'h00; @(negedge clk);
    chk("R9", "masked", irq, 0);
    int_en = 8'h33; idle(2);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_err++; n_chk++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule